// File: doc/BRIEF.md
# DMA Repeat-Mode Address and Count Sequencer

This block keeps the per-item bookkeeping of one DMA channel that runs in repeat mode. Every request the block accepts stands for the move of exactly one data item. The data move happens elsewhere, and its completion comes back to this block as a one-cycle done strobe. When that strobe arrives, the block advances the source and destination addresses and steps an inner item counter. It also steps an outer counter of repeat blocks. The block raises a sticky repeat-block-end flag and a sticky transfer-end flag.

Software programs the channel through a small write port. Through it, software sets the two start addresses, the block length and the block count, the address update mode of each side, the item size, a signed offset, and the choice of which side is the repeat area. It also sets whether the channel pauses at every block boundary. At the end of each block, the side chosen as the repeat area returns to its start address, and the other side keeps moving.

Top module: `dma_rpt_seq`

## Requirements
- R1: After a synchronous active-low reset, `ch_en`, `ack`, `rse_irq` and `te_irq` are 0 and both current addresses are 0.
- R2: While `ch_en` is 0, a request is never acknowledged and the current addresses do not change.
- R3: Only one item is in service at a time. After `ack` has been given, no further `ack` follows until a done strobe has been received. A request that is still held is acknowledged in the cycle after the update for that done strobe.
- R4: Each side has its own 2-bit update code: 00 keeps the address, 01 adds the signed 32-bit offset from register 4, 10 adds the item size and 11 subtracts it. The item size code in register 3 bits [7:6] selects 1 byte (00), 2 bytes (01) or 4 bytes (10 or 11). The source code sits in bits [1:0] and the destination code in bits [3:2].
- R5: The repeat-area select in register 3 bits [5:4] works as follows: 00 returns the destination to its start on the last item of a block, 01 returns the source, and 10 or 11 returns neither. The side that is not returned updates normally on that item.
- R6: The block length is register 2 bits [9:0], with 0 meaning 1024. The inner count reloads from this length after the last item of each block, so a repeat-area return happens after every block-length items.
- R7: When register 3 bit 8 is set, the last item of each block clears `ch_en` and sets `rse_irq`. Writing register 5 with bit 0 set enables the channel again, and the sequence continues from where it stopped.
- R8: The block count is register 2 bits [25:16], with 0 meaning 1024. When that many blocks have completed, `te_irq` is set and `ch_en` is cleared in the same cycle.
- R9: The two flags stay set until software clears them. A write to register 5 with bit 1 set clears `rse_irq`, and a write with bit 2 set clears `te_irq`. Register 5 bit 0 is the enable. Writing register 0 or 1 loads a start address and the current address together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Register index 0..5 |
| cfg_wdata | input | 32 | Write data |
| req | input | 1 | Transfer request, held until acknowledged |
| ack | output | 1 | Request accepted this cycle |
| done | input | 1 | One-cycle strobe: the item in service has moved |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| ch_en | output | 1 | Channel enable bit |
| rse_irq | output | 1 | Sticky repeat-block-end flag |
| te_irq | output | 1 | Sticky transfer-end flag |

## Verification
The bench targets the last item of a block, where a design that returns the wrong side, or returns one item too early or too late, would leave a visibly wrong address. It also targets a length or count of zero. A design that took zero literally would end the block or the transfer at once instead of after 1024 items. The pause-at-block option is checked by holding a request while the channel is paused, by re-enabling, and by clearing flags while the channel runs. A design that lost its counters on pause, or that dropped a flag on its own, would show it there. A held request with no done strobe must draw exactly one acknowledge.

// File: rtl/dma_rpt_pkg.sv
// Shared types and helpers for the repeat-mode sequencer.
// Assumes a 32-bit address space and register indices 0..5.
package dma_rpt_pkg;

    typedef enum logic [1:0] {
        UPD_FIXED  = 2'b00,
        UPD_OFFSET = 2'b01,
        UPD_INC    = 2'b10,
        UPD_DEC    = 2'b11
    } upd_mode_e;

    typedef enum logic [1:0] {
        AREA_DST   = 2'b00,
        AREA_SRC   = 2'b01,
        AREA_NONE  = 2'b10,
        AREA_NONE2 = 2'b11
    } area_e;

    localparam logic [2:0] REG_SRC_START = 3'd0;
    localparam logic [2:0] REG_DST_START = 3'd1;
    localparam logic [2:0] REG_SIZES     = 3'd2;
    localparam logic [2:0] REG_MODES     = 3'd3;
    localparam logic [2:0] REG_OFFSET    = 3'd4;
    localparam logic [2:0] REG_CTRL      = 3'd5;

    // Byte step for an item size code: 1, 2 or 4 bytes.
    function automatic logic [2:0] item_bytes(input logic [1:0] code);
        case (code)
            2'b00:   item_bytes = 3'd1;
            2'b01:   item_bytes = 3'd2;
            default: item_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_rpt_addr.sv
// One address side (source or destination).
// Holds the programmed start and the running address. On each completed
// item it either returns to the start or applies its update mode.
// Assumes ld and adv are not asserted together in normal use; ld wins.
module dma_rpt_addr
    import dma_rpt_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [AW-1:0] ld_val,
    input  logic          adv,
    input  logic          rewind,
    input  upd_mode_e     mode,
    input  logic [1:0]    isize,
    input  logic [AW-1:0] offset,
    output logic [AW-1:0] cur
);
    logic [AW-1:0] start_q;
    logic [AW-1:0] step_w;
    logic [AW-1:0] next_w;

    // Next address by update mode.
    always_comb begin
        step_w = AW'(item_bytes(isize));
        case (mode)
            UPD_FIXED:  next_w = cur;
            UPD_OFFSET: next_w = cur + offset;
            UPD_INC:    next_w = cur + step_w;
            default:    next_w = cur - step_w;
        endcase
    end

    // Start/current address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            cur     <= '0;
        end else if (ld) begin
            start_q <= ld_val;
            cur     <= ld_val;
        end else if (adv) begin
            cur <= rewind ? start_q : next_w;
        end
    end

    p_rewind_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && rewind && !ld) |=> (cur == $past(start_q)));

    p_fixed_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !rewind && !ld && mode == UPD_FIXED) |=> $stable(cur));

endmodule

// File: rtl/dma_rpt_cnt.sv
// Inner item counter and outer block counter.
// A code of zero for either length means 2**CW. Reports whether the item
// now in service is the last of its block and the last of the transfer.
module dma_rpt_cnt #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] size_code,
    input  logic [CW-1:0] cnt_code,
    input  logic          adv,
    output logic          blk_last,
    output logic          xfer_last
);
    localparam logic [CW:0] FULL = (CW+1)'(1) << CW;

    logic [CW:0] size_eff_q;
    logic [CW:0] cnt_eff_q;
    logic [CW:0] inner_q;
    logic [CW:0] outer_q;

    assign blk_last  = (inner_q == (CW+1)'(1));
    assign xfer_last = blk_last && (outer_q == (CW+1)'(1));

    // Programmed lengths and the two running counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_eff_q <= FULL;
            cnt_eff_q  <= FULL;
            inner_q    <= FULL;
            outer_q    <= FULL;
        end else if (load) begin
            size_eff_q <= (size_code == '0) ? FULL : {1'b0, size_code};
            cnt_eff_q  <= (cnt_code == '0) ? FULL : {1'b0, cnt_code};
            inner_q    <= (size_code == '0) ? FULL : {1'b0, size_code};
            outer_q    <= (cnt_code == '0) ? FULL : {1'b0, cnt_code};
        end else if (adv) begin
            if (blk_last) begin
                inner_q <= size_eff_q;
                outer_q <= xfer_last ? cnt_eff_q : outer_q - 1'b1;
            end else begin
                inner_q <= inner_q - 1'b1;
            end
        end
    end

    p_inner_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inner_q != '0) && (inner_q <= size_eff_q));

    p_outer_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && !blk_last) |=> $stable(outer_q));

endmodule

// File: rtl/dma_rpt_hs.sv
// Request/acknowledge handshake for one channel.
// Accepts a request only when enabled and idle; stays busy until the done
// strobe. Assumes done arrives only while an item is in service.
module dma_rpt_hs (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic req,
    input  logic done,
    output logic ack,
    output logic busy
);
    assign ack = !busy && en && req;

    // In-service flag.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy <= 1'b0;
        else if (ack)  busy <= 1'b1;
        else if (done) busy <= 1'b0;
    end

    p_single_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    p_done_in_service_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

endmodule

// File: rtl/dma_rpt_seq.sv
// Repeat-mode sequencer top: configuration registers, enable and flags,
// plus the handshake, counters and two address sides.
// Register indices are fixed by dma_rpt_pkg. Hardware disabling at a block
// or transfer end takes priority over a software enable write in the same cycle.
module dma_rpt_seq
    import dma_rpt_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    input  logic          req,
    output logic          ack,
    input  logic          done,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic          ch_en,
    output logic          rse_irq,
    output logic          te_irq
);
    localparam int SIDES   = 2;
    localparam int CNT_LSB = 16;

    upd_mode_e     mode_q [SIDES];
    area_e         area_q;
    logic [1:0]    isize_q;
    logic          stop_blk_q;
    logic [AW-1:0] offset_q;
    logic          busy;
    logic          xfer_done;
    logic          blk_last;
    logic          xfer_last;
    logic          hw_stop;
    logic          wr_ctrl;
    logic [AW-1:0] cur_w [SIDES];
    logic          ld_w  [SIDES];
    logic          rew_w [SIDES];

    assign xfer_done = done && busy;
    assign hw_stop   = xfer_done && (xfer_last || (blk_last && stop_blk_q));
    assign wr_ctrl   = cfg_we && (cfg_addr == REG_CTRL);

    // Mode and offset configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q[0]  <= UPD_FIXED;
            mode_q[1]  <= UPD_FIXED;
            area_q     <= AREA_DST;
            isize_q    <= 2'b00;
            stop_blk_q <= 1'b0;
            offset_q   <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == REG_MODES) begin
                mode_q[0]  <= upd_mode_e'(cfg_wdata[1:0]);
                mode_q[1]  <= upd_mode_e'(cfg_wdata[3:2]);
                area_q     <= area_e'(cfg_wdata[5:4]);
                isize_q    <= cfg_wdata[7:6];
                stop_blk_q <= cfg_wdata[8];
            end
            if (cfg_addr == REG_OFFSET) offset_q <= cfg_wdata[AW-1:0];
        end
    end

    // Channel enable: hardware stop first, then software write.
    always_ff @(posedge clk) begin
        if (!rst_n)       ch_en <= 1'b0;
        else if (hw_stop) ch_en <= 1'b0;
        else if (wr_ctrl) ch_en <= cfg_wdata[0];
    end

    // Sticky flags: a set event wins over a clear write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rse_irq <= 1'b0;
            te_irq  <= 1'b0;
        end else begin
            if (xfer_done && blk_last && stop_blk_q) rse_irq <= 1'b1;
            else if (wr_ctrl && cfg_wdata[1])        rse_irq <= 1'b0;
            if (xfer_done && xfer_last)              te_irq  <= 1'b1;
            else if (wr_ctrl && cfg_wdata[2])        te_irq  <= 1'b0;
        end
    end

    dma_rpt_hs u_hs (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ch_en),
        .req   (req),
        .done  (done),
        .ack   (ack),
        .busy  (busy)
    );

    dma_rpt_cnt #(.CW(CW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cfg_we && (cfg_addr == REG_SIZES)),
        .size_code (cfg_wdata[CW-1:0]),
        .cnt_code  (cfg_wdata[CNT_LSB+CW-1:CNT_LSB]),
        .adv       (xfer_done),
        .blk_last  (blk_last),
        .xfer_last (xfer_last)
    );

    // Side 0 is the source, side 1 the destination.
    for (genvar g = 0; g < SIDES; g++) begin : g_side
        assign ld_w[g]  = cfg_we && (cfg_addr == ((g == 0) ? REG_SRC_START : REG_DST_START));
        assign rew_w[g] = blk_last && (area_q == ((g == 0) ? AREA_SRC : AREA_DST));

        dma_rpt_addr #(.AW(AW)) u_addr (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (ld_w[g]),
            .ld_val (cfg_wdata[AW-1:0]),
            .adv    (xfer_done),
            .rewind (rew_w[g]),
            .mode   (mode_q[g]),
            .isize  (isize_q),
            .offset (offset_q),
            .cur    (cur_w[g])
        );
    end

    assign src_addr = cur_w[0];
    assign dst_addr = cur_w[1];

    p_ack_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> ch_en);

    p_te_disables_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(te_irq) |-> !ch_en);

    p_rse_pauses_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rse_irq) |-> !ch_en);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cfg_we) |=> ($stable(src_addr) && $stable(dst_addr)));

endmodule

// File: tb/dma_rpt_seq_tb_top.sv
module dma_rpt_seq_tb_top;

    typedef struct packed {
        logic [8:0]  modes;
        logic [31:0] offset;
        logic [9:0]  rsize;
        logic [9:0]  rcnt;
        logic [15:0] n;
        logic [31:0] exp_src;
        logic [31:0] exp_dst;
        logic        exp_te;
        logic        exp_en;
    } vec_t;

    // modes = {stop, isize[1:0], area[1:0], dst[1:0], src[1:0]}
    localparam vec_t VECS [5] = '{
        '{9'h08A, 32'h0,        10'd3, 10'd5, 16'd4, 32'h1010, 32'h2004, 1'b0, 1'b1},
        '{9'h053, 32'h0,        10'd2, 10'd4, 16'd3, 32'h0FFE, 32'h2000, 1'b0, 1'b1},
        '{9'h025, 32'hFFFFFFF8, 10'd2, 10'd2, 16'd4, 32'h0FE0, 32'h1FE0, 1'b1, 1'b0},
        '{9'h00E, 32'h0,        10'd5, 10'd1, 16'd5, 32'h1005, 32'h2000, 1'b1, 1'b0},
        '{9'h038, 32'h0,        10'd2, 10'd3, 16'd3, 32'h1000, 32'h2003, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req = 1'b0;
    logic        done = 1'b0;
    logic        ack;
    logic [31:0] src_addr;
    logic [31:0] dst_addr;
    logic        ch_en;
    logic        rse_irq;
    logic        te_irq;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #5 clk = ~clk;

    dma_rpt_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req(req), .ack(ack), .done(done),
        .src_addr(src_addr), .dst_addr(dst_addr), .ch_en(ch_en),
        .rse_irq(rse_irq), .te_irq(te_irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_item();
        req = 1'b1;
        #1;
        while (!ack) @(negedge clk);
        @(negedge clk);
        req = 1'b0;
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
    endtask

    task automatic setup(input logic [8:0] modes, input logic [31:0] off,
                         input logic [9:0] rs, input logic [9:0] rc);
        wr(3'd5, 32'h6);
        wr(3'd0, 32'h1000);
        wr(3'd1, 32'h2000);
        wr(3'd3, {23'd0, modes});
        wr(3'd4, off);
        wr(3'd2, {6'd0, rc, 6'd0, rs});
        wr(3'd5, 32'h1);
    endtask

    initial begin
        int acks;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ch_en", {31'd0, ch_en}, 32'd0);
        chk("R1 ack", {31'd0, ack}, 32'd0);
        chk("R1 irqs", {30'd0, rse_irq, te_irq}, 32'd0);
        chk("R1 src", src_addr, 32'd0);
        chk("R1 dst", dst_addr, 32'd0);

        // R4 R5 R6 R8 table walk
        foreach (VECS[i]) begin
            setup(VECS[i].modes, VECS[i].offset, VECS[i].rsize, VECS[i].rcnt);
            for (int k = 0; k < int'(VECS[i].n); k++) do_item();
            chk($sformatf("R4/R5 row%0d src", i), src_addr, VECS[i].exp_src);
            chk($sformatf("R4/R5 row%0d dst", i), dst_addr, VECS[i].exp_dst);
            chk($sformatf("R8 row%0d te", i), {31'd0, te_irq}, {31'd0, VECS[i].exp_te});
            chk($sformatf("R6 row%0d en", i), {31'd0, ch_en}, {31'd0, VECS[i].exp_en});
        end

        // R2: disabled channel ignores requests
        wr(3'd5, 32'h6);
        wr(3'd0, 32'h1000);
        wr(3'd3, 32'h022);
        req = 1'b1;
        acks = 0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (ack) acks++;
        end
        req = 1'b0;
        chk("R2 no ack while disabled", acks, 0);
        chk("R2 src unchanged", src_addr, 32'h1000);

        // R3: one item in service at a time
        setup(9'h022, 32'h0, 10'd4, 10'd4);
        req = 1'b1;
        acks = 0;
        for (int k = 0; k < 6; k++) begin
            #1;
            if (ack) acks++;
            @(negedge clk);
        end
        chk("R3 single ack without done", acks, 1);
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        #1;
        chk("R3 re-ack after update", {31'd0, ack}, 32'd1);
        req = 1'b0;
        @(negedge clk);
        chk("R3 one item moved", src_addr, 32'h1001);

        // R6: length 0 means 1024, source is repeat area
        setup(9'h012, 32'h0, 10'd0, 10'd2);
        for (int k = 0; k < 1023; k++) do_item();
        chk("R6 before block end", src_addr, 32'h13FF);
        do_item();
        chk("R6 return after 1024 items", src_addr, 32'h1000);
        chk("R6 still enabled", {31'd0, ch_en}, 32'd1);

        // R7 R9: pause at each block
        setup(9'h122, 32'h0, 10'd2, 10'd3);
        do_item();
        do_item();
        chk("R7 paused", {31'd0, ch_en}, 32'd0);
        chk("R7 rse set", {31'd0, rse_irq}, 32'd1);
        req = 1'b1;
        acks = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (ack) acks++;
        end
        req = 1'b0;
        chk("R7 no ack while paused", acks, 0);
        chk("R7 src after pause", src_addr, 32'h1002);
        wr(3'd5, 32'h1);
        chk("R7 resumed", {31'd0, ch_en}, 32'd1);
        chk("R9 rse sticky", {31'd0, rse_irq}, 32'd1);
        wr(3'd5, 32'h3);
        chk("R9 rse cleared", {31'd0, rse_irq}, 32'd0);
        do_item();
        do_item();
        chk("R7 second pause", {31'd0, ch_en}, 32'd0);
        chk("R7 src continues", src_addr, 32'h1004);
        wr(3'd5, 32'h3);
        do_item();
        do_item();
        chk("R8 te after last block", {31'd0, te_irq}, 32'd1);
        chk("R8 disabled at end", {31'd0, ch_en}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R9 te sticky", {31'd0, te_irq}, 32'd1);
        wr(3'd5, 32'h4);
        chk("R9 te cleared", {31'd0, te_irq}, 32'd0);

        // R8: count 0 means 1024 blocks
        setup(9'h022, 32'h0, 10'd1, 10'd0);
        for (int k = 0; k < 1023; k++) do_item();
        chk("R8 no te before 1024", {31'd0, te_irq}, 32'd0);
        do_item();
        chk("R8 te at 1024", {31'd0, te_irq}, 32'd1);
        chk("R8 src at end", src_addr, 32'h1400);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule